// File: doc/BRIEF.md
# SCL Phase Tick Generator

This block produces the timing pulses that step a two-wire serial master through its SCL waveform, starting from a fast system clock. Software loads an 8-bit rate word. The block divides the system clock in three stages. A linear stage counts M+1 cycles. A binary stage counts 2^(N+1) of those. A fixed ten-phase stage then walks through the bit phases of one SCL period. One full SCL period therefore spans 10·(M+1)·2^(N+1) system clock cycles.

The outputs are single-cycle enables, and no derived clock is produced, so the consuming master stays in the system clock domain. A phase pulse marks each step from one phase to the next. A period pulse marks the start of each new SCL period. A phase index tells the master which of the ten phases it is in. Any write to the rate word clears every stage, so the new ratio starts from a clean phase zero.

Top module: `scl_rate_gen`

## Requirements
- R1: With rst high, and in the first cycle after rst falls, phase_tick and period_tick are 0 and phase_idx is 0. The reset rate word has M=0 and N=0, so phase pulses then come every 2 cycles.
- R2: In the rate word, M is taken from cfg_data bits [6:3] and N from bits [2:0]. Bit 7 has no effect on any output.
- R3: phase_tick is high for one cycle at a time, and successive rising edges are exactly K = (M+1)·2^(N+1) cycles apart.
- R4: phase_idx changes only in a cycle in which phase_tick is high. It advances by one from 0 to 9 and then returns to 0. It always stays below 10.
- R5: period_tick is high only together with phase_tick, and only when phase_idx has just returned to 0. Its pulses are 10·K cycles apart.
- R6: A cycle with cfg_we high loads the rate word and clears all stages. In the following cycle phase_tick is 0 and phase_idx is 0. The first phase_tick then appears exactly K cycles after that write edge. This holds even when the written value equals the old one.
- R7: The extreme settings give the expected intervals: M=0,N=0 gives K=2, and M=15,N=7 gives K=4096, with a period of 40960 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Rate word write strobe |
| cfg_data | input | 8 | Rate word: M in [6:3], N in [2:0], bit 7 unused |
| phase_tick | output | 1 | One-cycle pulse at each SCL phase step |
| period_tick | output | 1 | One-cycle pulse at the start of each SCL period |
| phase_idx | output | 4 | Current SCL phase, 0 to 9 |

## Verification
A linear stage that is off by one stretches or shrinks every phase interval by 2^(N+1) cycles. The binary stage misreading N doubles or halves the interval. Either fault shows on the very first phase_tick after a write, so the bench times that first pulse as well as the steady spacing. A ten-phase counter that wraps at the wrong count shows up in phase_idx within one period, and it also moves period_tick off its 10·K spacing. A write that fails to clear a stage shifts the first pulse after a mid-count rewrite.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    // Field widths of the rate word and the fixed phase count
    parameter int M_W    = 4;
    parameter int N_W    = 3;
    parameter int PHASES = 10;
    parameter int CFG_W  = 8;

    // Derived sizes
    localparam int BIN_W = 2 ** N_W;          // binary stage counts up to 2^(2^N_W)
    localparam int PH_W  = $clog2(PHASES);

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } baud_t;

    typedef struct packed {
        logic lin_ev;   // end of linear stage
        logic bin_ev;   // end of binary stage (one phase)
    } stage_ev_t;

    // Pull M and N out of the written word; upper bits are dropped.
    function automatic baud_t unpack_baud(input logic [CFG_W-1:0] d);
        baud_t r;
        r.m = d[N_W+M_W-1:N_W];
        r.n = d[N_W-1:0];
        return r;
    endfunction

    // Terminal count of the binary stage: 2^(n+1) - 1
    function automatic logic [BIN_W-1:0] bin_last(input logic [N_W-1:0] n);
        return {BIN_W{1'b1}} >> (BIN_W - 1 - int'(n));
    endfunction

endpackage

// File: rtl/scl_div_linear.sv
module scl_div_linear
    import scl_div_pkg::*;
#(
    parameter int W = M_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = (cnt == limit);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/scl_div_binary.sv
module scl_div_binary
    import scl_div_pkg::*;
#(
    parameter int SEL_W = N_W,
    parameter int W     = BIN_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    logic [W-1:0] cnt;
    logic [W-1:0] last;

    assign last = bin_last(sel);
    assign done = step && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (step) begin
            if (cnt == last) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scl_div_phase.sv
module scl_div_phase
    import scl_div_pkg::*;
#(
    parameter int NPH = PHASES,
    parameter int W   = PH_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] idx,
    output logic         step_q,
    output logic         wrap_q
);
    localparam logic [W-1:0] LAST = W'(NPH - 1);

    logic at_last;
    assign at_last = (idx == LAST);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            idx    <= '0;
            step_q <= 1'b0;
            wrap_q <= 1'b0;
        end else begin
            step_q <= step;
            wrap_q <= step && at_last;
            if (step) begin
                idx <= at_last ? '0 : idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen
    import scl_div_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_data,
    output logic             phase_tick,
    output logic             period_tick,
    output logic [PH_W-1:0]  phase_idx
);
    baud_t     baud;
    stage_ev_t ev;
    logic      unused_hi;

    assign unused_hi = ^cfg_data[CFG_W-1:M_W+N_W];

    // Rate word register
    always_ff @(posedge clk) begin
        if (rst) begin
            baud <= '0;
        end else if (cfg_we) begin
            baud <= unpack_baud(cfg_data);
        end
    end

    scl_div_linear #(.W(M_W)) u_lin (
        .clk   (clk),
        .rst   (rst),
        .clr   (cfg_we),
        .limit (baud.m),
        .done  (ev.lin_ev)
    );

    scl_div_binary #(.SEL_W(N_W), .W(BIN_W)) u_bin (
        .clk  (clk),
        .rst  (rst),
        .clr  (cfg_we),
        .step (ev.lin_ev),
        .sel  (baud.n),
        .done (ev.bin_ev)
    );

    scl_div_phase #(.NPH(PHASES), .W(PH_W)) u_ph (
        .clk    (clk),
        .rst    (rst),
        .clr    (cfg_we),
        .step   (ev.bin_ev),
        .idx    (phase_idx),
        .step_q (phase_tick),
        .wrap_q (period_tick)
    );
endmodule

// File: rtl/scl_rate_gen_chk.sv
module scl_rate_gen_chk
    import scl_div_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cfg_we,
    input logic            phase_tick,
    input logic            period_tick,
    input logic [PH_W-1:0] phase_idx
);
    localparam logic [PH_W-1:0] LAST = PH_W'(PHASES - 1);

    // R4
    idx_range_chk: assert property (@(posedge clk) disable iff (rst)
        phase_idx <= LAST);

    // R4
    idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!phase_tick && !$past(cfg_we)) |-> $stable(phase_idx));

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        phase_tick |-> phase_idx == (($past(phase_idx) == LAST) ? '0 : $past(phase_idx) + 1'b1));

    // R5
    period_align_chk: assert property (@(posedge clk) disable iff (rst)
        period_tick |-> (phase_tick && phase_idx == '0));

    // R6
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (!phase_tick && phase_idx == '0));

    // R3
    tick_width_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_tick && !cfg_we) |=> !phase_tick);
endmodule

bind scl_rate_gen scl_rate_gen_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .phase_tick  (phase_tick),
    .period_tick (period_tick),
    .phase_idx   (phase_idx)
);

// File: tb/scl_rate_gen_tb.sv
module scl_rate_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_data = '0;
    logic       phase_tick;
    logic       period_tick;
    logic [3:0] phase_idx;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #5 clk = ~clk;

    scl_rate_gen u_dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_we      (cfg_we),
        .cfg_data    (cfg_data),
        .phase_tick  (phase_tick),
        .period_tick (period_tick),
        .phase_idx   (phase_idx)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Wait at negedges until phase_tick; returns number of negedges waited.
    task automatic wait_tick(output int n);
        n = 0;
        while (!phase_tick && n < 60000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_period(output int n);
        n = 0;
        while (!period_tick && n < 60000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Write rate word; returns at negedge of the cycle after the write edge.
    task automatic write_cfg(input logic [7:0] d);
        @(negedge clk);
        cfg_data = d;
        cfg_we   = 1'b1;
        @(negedge clk);
        cfg_we   = 1'b0;
    endtask

    function automatic int kval(input int m, input int n);
        return (m + 1) * (2 ** (n + 1));
    endfunction

    task automatic t_reset();
        int w;
        repeat (4) @(negedge clk);
        chk(phase_tick == 0 && period_tick == 0 && phase_idx == 0, "R1 outputs in reset",
            phase_idx, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(phase_tick == 0 && period_tick == 0 && phase_idx == 0, "R1 first cycle after reset",
            {phase_tick, period_tick}, 0);
        wait_tick(w);
        @(negedge clk);
        wait_tick(w);
        chk(w == 1, "R1 default interval (negedges after low cycle)", w + 1, 2);
    endtask

    task automatic t_rate(input logic [7:0] d, input int m, input int n, input string req);
        int w, k, exp_idx;
        k = kval(m, n);
        write_cfg(d);
        chk(phase_tick == 0 && phase_idx == 0, {req, " R6 quiet after write"}, phase_idx, 0);
        wait_tick(w);
        chk(w == k, {req, " R6 first tick delay"}, w, k);
        chk(phase_idx == 1, {req, " R4 idx after first tick"}, phase_idx, 1);
        exp_idx = 1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(phase_tick == 0, {req, " R3 single-cycle pulse"}, phase_tick, 0);
            wait_tick(w);
            chk(w + 1 == k, {req, " R3 tick interval"}, w + 1, k);
            exp_idx = (exp_idx + 1) % 10;
            chk(phase_idx == exp_idx, {req, " R4 idx step"}, phase_idx, exp_idx);
        end
    endtask

    task automatic t_period(input logic [7:0] d, input int m, input int n, input string req);
        int w, k;
        k = kval(m, n);
        write_cfg(d);
        wait_period(w);
        chk(w == 10 * k, {req, " R5 first period delay"}, w, 10 * k);
        chk(phase_tick == 1 && phase_idx == 0, {req, " R5 period aligned to phase 0"},
            phase_idx, 0);
    endtask

    task automatic t_period_spacing(input logic [7:0] d, input int m, input int n);
        int w, k;
        k = kval(m, n);
        write_cfg(d);
        wait_period(w);
        @(negedge clk);
        chk(period_tick == 0, "R5 period pulse width", period_tick, 0);
        wait_period(w);
        chk(w + 1 == 10 * k, "R5 period spacing", w + 1, 10 * k);
    endtask

    task automatic t_restart();
        int w, k;
        k = kval(3, 2);
        write_cfg({1'b0, 4'd3, 3'd2});
        repeat (k + k / 2) @(negedge clk);
        write_cfg({1'b0, 4'd3, 3'd2});
        chk(phase_idx == 0 && phase_tick == 0, "R6 same-value rewrite clears", phase_idx, 0);
        wait_tick(w);
        chk(w == k, "R6 restart delay", w, k);
    endtask

    initial begin
        t_reset();
        t_rate({1'b0, 4'd3, 3'd2}, 3, 2, "R2 M3N2");
        t_rate({1'b1, 4'd3, 3'd2}, 3, 2, "R2 bit7 ignored");
        t_rate({1'b0, 4'd5, 3'd0}, 5, 0, "R2 M5N0");
        t_rate({1'b0, 4'd0, 3'd0}, 0, 0, "R7 M0N0");
        t_rate({1'b0, 4'd0, 3'd7}, 0, 7, "R2 M0N7");
        t_rate({1'b0, 4'd15, 3'd7}, 15, 7, "R7 M15N7");
        t_period({1'b0, 4'd2, 3'd1}, 2, 1, "R5 M2N1");
        t_period_spacing({1'b0, 4'd1, 3'd0}, 1, 0);
        t_period({1'b0, 4'd15, 3'd7}, 15, 7, "R7 slowest");
        t_restart();
        done_flag = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (180000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule